// File: doc/BRIEF.md
# Vector Quadword Bit Permute Unit

This unit gathers sixteen single bits out of a 128-bit data vector and packs them into a small field of a 128-bit result. A second 128-bit vector steers the gather: it is read as sixteen unsigned byte-wide bit indices, one per byte lane. Each lane picks one bit of the data vector, using numbering that starts at the most significant bit. An index of 128 or more yields a zero bit. The sixteen gathered bits form a 16-bit field. The field sits in the low end of the upper doubleword of the result, and every other result bit is zero.

The unit has one register stage. Each operand pair presented with `in_valid` appears as a result one clock later, flagged by `out_valid`. A new pair may be presented on every cycle.

The output stage is a two-state machine:
- `ST_IDLE`: no result is presented.
- `ST_LIVE`: the result register holds a result that was accepted on the previous cycle.

Its transitions are named as follows:
- accept (IDLE→LIVE on `in_valid`).
- stream (LIVE→LIVE on `in_valid`).
- drain (LIVE→IDLE without `in_valid`).
- rest (IDLE→IDLE without `in_valid`).

Reset forces `ST_IDLE`.

Top module: `vbp_unit`

## Requirements
- R1: Byte lane i (0..15) takes its index from `opnd_ctl[127-8i -: 8]`, so lane 0 is the most significant byte. The bit that lane i gathers lands at result bit 64+15-i, so lane 0 drives bit 79 and lane 15 drives bit 64.
- R2: An index k below 128 selects `opnd_a[127-k]`. Index bit 6 clear selects the upper doubleword and set selects the lower doubleword, and index bits 5..0 count down from the most significant bit of that doubleword. So 0 selects bit 127, 63 selects bit 64, 64 selects bit 63 and 127 selects bit 0.
- R3: A lane whose index is 128 or greater contributes 0, whatever `opnd_a` holds.
- R4: Result bits 127..80 are always zero.
- R5: Result bits 63..0 are always zero.
- R6: `out_valid` is high in the cycle after `in_valid` is high, and `out_result` then holds the result for the operands of that cycle. Operand pairs on consecutive cycles each produce a result on consecutive cycles.
- R7: A cycle with `in_valid` low is followed by `out_valid` low, and `out_result` keeps its previous value whatever the operand inputs carry.
- R8: A synchronous active-high `rst` clears `out_result` to zero and `out_valid` to low at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on this cycle are to be processed |
| opnd_a | input | 128 | Data vector the bits are gathered from |
| opnd_ctl | input | 128 | Sixteen byte-wide bit indices, lane 0 in the top byte |
| out_valid | output | 1 | `out_result` holds a result accepted on the previous cycle |
| out_result | output | 128 | Gathered 16-bit field in bits 79..64, all other bits zero |

## Verification
The gather path has no internal state, so a wrong lane decode or a wrong bit select shows up in the very next result as one flipped or misplaced bit in bits 79..64. Sweeping every index value through every lane exposes it within a few hundred results. A fault in the output state machine or the result register shows up one cycle after the stimulus, in one of three ways:
- `out_valid` is out of step with `in_valid`.
- The result changes on a cycle with no accepted operands.
- A nonzero value survives reset.

Stray bits outside the field are visible in any result.

// File: rtl/vbp_pkg.sv
package vbp_pkg;
    localparam int VBP_LANES = 16;
    localparam int VBP_IDX_W = 8;
    localparam int VBP_VEC_W = 128;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LIVE = 1'b1
    } vbp_state_e;
endpackage

// File: rtl/vbp_lane_pick.sv
module vbp_lane_pick #(
    parameter int VEC_W = 128,
    parameter int IDX_W = 8
) (
    input  logic [VEC_W-1:0] src,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    localparam int DW_W  = VEC_W / 2;
    localparam int OFS_W = $clog2(DW_W);

    logic             in_range;
    logic             lower_sel;
    logic [OFS_W-1:0] ofs;
    logic [OFS_W-1:0] rev_ofs;
    logic [DW_W-1:0]  word;

    always_comb begin
        in_range  = (32'(idx) < 32'(VEC_W));
        lower_sel = idx[OFS_W];
        ofs       = idx[OFS_W-1:0];
        // offset counts from the doubleword's top bit
        rev_ofs   = ~ofs;
        word      = lower_sel ? src[DW_W-1:0] : src[VEC_W-1:DW_W];
        bit_o     = in_range & word[rev_ofs];
    end
endmodule

// File: rtl/vbp_gather.sv
module vbp_gather #(
    parameter int VEC_W = 128,
    parameter int IDX_W = 8,
    parameter int LANES = 16
) (
    input  logic [VEC_W-1:0]       src,
    input  logic [LANES*IDX_W-1:0] ctl,
    output logic [LANES-1:0]       field
);
    localparam int CTL_W = LANES * IDX_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vbp_lane_pick #(
            .VEC_W(VEC_W),
            .IDX_W(IDX_W)
        ) u_pick (
            .src  (src),
            .idx  (ctl[CTL_W-1-IDX_W*g -: IDX_W]),
            .bit_o(field[LANES-1-g])
        );
    end
endmodule

// File: rtl/vbp_pack.sv
module vbp_pack #(
    parameter int VEC_W = 128,
    parameter int LANES = 16
) (
    input  logic [LANES-1:0] field,
    output logic [VEC_W-1:0] res
);
    localparam int DW_W = VEC_W / 2;

    always_comb begin
        res              = '0;
        res[DW_W +: LANES] = field;
    end
endmodule

// File: rtl/vbp_out_stage.sv
module vbp_out_stage
    import vbp_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] d,
    output logic             out_valid,
    output logic [VEC_W-1:0] q
);
    vbp_state_e state;
    vbp_state_e nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // transitions: accept, stream, drain, rest
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = in_valid ? ST_LIVE : ST_IDLE;
            ST_LIVE: nxt = in_valid ? ST_LIVE : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (in_valid) q <= d;
    end

    always_comb out_valid = (state == ST_LIVE);
endmodule

// File: rtl/vbp_unit.sv
module vbp_unit
    import vbp_pkg::*;
#(
    parameter int VEC_W = VBP_VEC_W,
    parameter int IDX_W = VBP_IDX_W,
    parameter int LANES = VBP_LANES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [VEC_W-1:0]       opnd_a,
    input  logic [LANES*IDX_W-1:0] opnd_ctl,
    output logic                   out_valid,
    output logic [VEC_W-1:0]       out_result
);
    logic [LANES-1:0] field;
    logic [VEC_W-1:0] packed_res;

    vbp_gather #(
        .VEC_W(VEC_W),
        .IDX_W(IDX_W),
        .LANES(LANES)
    ) u_gather (
        .src  (opnd_a),
        .ctl  (opnd_ctl),
        .field(field)
    );

    vbp_pack #(
        .VEC_W(VEC_W),
        .LANES(LANES)
    ) u_pack (
        .field(field),
        .res  (packed_res)
    );

    vbp_out_stage #(
        .VEC_W(VEC_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .d        (packed_res),
        .out_valid(out_valid),
        .q        (out_result)
    );
endmodule

// File: rtl/vbp_unit_chk.sv
module vbp_unit_chk #(
    parameter int VEC_W = 128,
    parameter int IDX_W = 8,
    parameter int LANES = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [VEC_W-1:0]       opnd_a,
    input logic [LANES*IDX_W-1:0] opnd_ctl,
    input logic                   out_valid,
    input logic [VEC_W-1:0]       out_result
);
    localparam int DW_W = VEC_W / 2;
    localparam int TOP  = VEC_W - DW_W - LANES;

    function automatic logic all_oor(input logic [LANES*IDX_W-1:0] c);
        logic r;
        r = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (32'(c[i*IDX_W +: IDX_W]) < 32'(VEC_W)) r = 1'b0;
        end
        return r;
    endfunction

    logic oor_now;
    logic unused_a;
    always_comb oor_now  = all_oor(opnd_ctl);
    always_comb unused_a = ^opnd_a;

    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_result_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    assert_all_oor_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && oor_now) |=> (out_result[DW_W +: LANES] == '0));

    assert_upper_clear_R4: assert property (@(posedge clk) disable iff (rst)
        out_result[VEC_W-1 -: TOP] == '0);

    assert_lower_clear_R5: assert property (@(posedge clk) disable iff (rst)
        out_result[DW_W-1:0] == '0);

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));
endmodule

bind vbp_unit vbp_unit_chk #(
    .VEC_W(VEC_W),
    .IDX_W(IDX_W),
    .LANES(LANES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opnd_a    (opnd_a),
    .opnd_ctl  (opnd_ctl),
    .out_valid (out_valid),
    .out_result(out_result)
);

// File: tb/sim_vbp_unit.sv
`timescale 1ns/1ps
module sim_vbp_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_ctl = '0;
    logic         out_valid;
    logic [127:0] out_result;

    int checks = 0;
    int errors = 0;

    logic [127:0] exp_res = '0;
    logic         exp_valid = 1'b0;
    logic         armed = 1'b0;
    string        cur_tag = "R8";

    always #(CLK_PERIOD/2) clk = ~clk;

    vbp_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .opnd_a    (opnd_a),
        .opnd_ctl  (opnd_ctl),
        .out_valid (out_valid),
        .out_result(out_result)
    );

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b);
        logic [15:0] f;
        int k;
        f = '0;
        for (int i = 0; i < 16; i++) begin
            k = int'(b[127-8*i -: 8]);
            if (k < 128) f[15-i] = a[127-k];
        end
        return {48'h0, f, 64'h0};
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_vec(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic verify();
        if (armed) begin
            check_bit(exp_valid ? "R6" : "R7", out_valid, exp_valid);
            check_vec("R4", {out_result[127:80], 80'h0}, 128'h0);
            check_vec("R5", {64'h0, out_result[63:0]}, 128'h0);
            check_vec(cur_tag, out_result, exp_res);
        end
    endtask

    task automatic step(input string tag, input logic [127:0] a, input logic [127:0] b, input logic v);
        @(negedge clk);
        verify();
        opnd_a   = a;
        opnd_ctl = b;
        in_valid = v;
        if (v) exp_res = model(a, b);
        exp_valid = v;
        cur_tag   = tag;
        armed     = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        verify();
        rst      = 1'b1;
        in_valid = 1'b1;
        opnd_a   = '1;
        opnd_ctl = '0;
        @(negedge clk);
        check_bit("R8", out_valid, 1'b0);
        check_vec("R8", out_result, 128'h0);
        rst       = 1'b0;
        in_valid  = 1'b0;
        exp_res   = '0;
        exp_valid = 1'b0;
        cur_tag   = "R7";
        armed     = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] b;
        repeat (2) @(negedge clk);
        check_bit("R8", out_valid, 1'b0);
        check_vec("R8", out_result, 128'h0);
        rst = 1'b0;

        // R3: every index out of range, A all ones
        step("R3", '1, {16{8'h80}}, 1'b1);
        step("R3", '1, {8'hFF, 8'h80, 8'hC3, 8'h9A, {12{8'hF0}}}, 1'b1);
        // R2: boundary indices 0/63/64/127
        step("R2", {1'b1, 62'h0, 1'b1, 1'b1, 62'h0, 1'b1},
             {4{8'd0, 8'd63, 8'd64, 8'd127}}, 1'b1);
        step("R2", {1'b0, {62{1'b1}}, 1'b0, 1'b0, {62{1'b1}}, 1'b0},
             {4{8'd0, 8'd63, 8'd64, 8'd127}}, 1'b1);
        // repeated identical indices, A ones then zeros
        step("R1", '1, {16{8'd42}}, 1'b1);
        step("R1", '0, {16{8'd42}}, 1'b1);
        step("R1", '1, {8{8'd5, 8'd200}}, 1'b1);

        // R7: idle cycles with junk operands hold the result
        step("R7", rnd128(), rnd128(), 1'b0);
        step("R7", '1, '0, 1'b0);

        // R2: each in-range index against a one-hot and a one-cold A
        for (int p = 0; p < 128; p++) begin
            step("R2", 128'h1 << (127 - p), {16{8'(p)}}, 1'b1);
            step("R2", ~(128'h1 << (127 - p)), {16{8'(p)}}, 1'b1);
        end

        // R1: every index value in every lane, streamed back to back
        for (int k = 0; k < 256; k++) begin
            b = '0;
            for (int i = 0; i < 16; i++) b[127-8*i -: 8] = 8'(k + 17 * i);
            step("R1", rnd128(), b, 1'b1);
        end

        do_reset();

        // R6: random stream with occasional gaps
        for (int n = 0; n < 1500; n++) begin
            step(((n % 7) == 3) ? "R7" : "R6", rnd128(), rnd128(), (n % 7) != 3);
        end
        step("R7", '0, '0, 1'b0);
        @(negedge clk);
        verify();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule